// File: doc/BRIEF.md
# Descriptor Completion Decision Unit

When a DMA channel finishes a descriptor, this block decides three things. It decides whether the channel raises an interrupt, whether it stalls on the descriptor, and whether the command pointer branches to a new address or moves on to the next descriptor. Each decision has its own 2-bit policy field in the descriptor command word and its own select register. All three decisions compare against the same four device-status bits from the channel status register. The block also owns the branch-taken status flag.

The channel sequencer presents one completed descriptor on `in_valid`/`in_ready`. This carries the policy bits, a snapshot of the device-status bits, the three select words, the current command pointer and the descriptor's dependent-address word. The verdict comes back one cycle after acceptance on `res_valid`/`res_ready`. A verdict stays on its pins until `res_ready` is high. While a verdict is pending and not taken, `in_ready` is low, so the sequencer cannot overwrite it. `in_ready` is high whenever the result slot is empty or is being emptied in the same cycle. The interrupt is a separate one-cycle pulse, and the branch-taken flag is a plain status level.

Top module: `dsc_decide`

## Requirements
- R1: In every select word, bits 19:16 are a 4-bit mask and bits 3:0 are a 4-bit compare value. The condition is true when every status bit selected by the mask equals the matching compare bit. A zero mask makes the condition true.
- R2: The interrupt policy follows the encoding 00 = never, 01 = when the condition is true, 10 = when the condition is false, 11 = always. When the policy fires, `irq_pulse` is high for exactly the one cycle after the accepting edge.
- R3: The wait policy uses the same encoding. A descriptor that stalls reports `res_wait`=1. It raises no interrupt, does not branch, returns the unchanged command pointer and leaves `bt_flag` as it was.
- R4: A branch that is taken, on a descriptor that does not stall, returns the dependent-address word as the new pointer, reports `res_branch`=1 and sets `bt_flag`. `bt_flag` changes only on an accepted descriptor.
- R5: A branch that is not taken, on a descriptor that does not stall, returns the command pointer plus 16, reports `res_branch`=0 and clears `bt_flag`.
- R6: The interrupt, branch and wait decisions each use their own select word. All three are evaluated from the single status snapshot taken at the accepting edge.
- R7: A verdict is held unchanged while `res_valid` is high and `res_ready` is low. During that time `in_ready` is low.
- R8: After reset, `res_valid`, `irq_pulse` and `bt_flag` are 0.
- R9: The policy fields sit at command bits 5:4 (interrupt), 3:2 (branch) and 1:0 (wait).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Completed descriptor presented |
| in_ready | output | 1 | Block can accept a descriptor |
| pol_bits | input | 6 | Interrupt/branch/wait policy fields |
| dev_stat | input | SW (4) | Device-status bits snapshot |
| irq_sel | input | 32 | Interrupt select word |
| wait_sel | input | 32 | Wait select word |
| br_sel | input | 32 | Branch select word |
| cmd_ptr | input | AW (32) | Current command pointer |
| dep_addr | input | AW (32) | Dependent-address (branch target) word |
| res_valid | output | 1 | Verdict available |
| res_ready | input | 1 | Consumer takes the verdict |
| res_wait | output | 1 | Descriptor stalls |
| res_branch | output | 1 | Branch taken |
| res_ptr | output | AW (32) | Next command pointer |
| irq_pulse | output | 1 | One-cycle interrupt request |
| bt_flag | output | 1 | Branch-taken status flag |

## Verification
Every verdict field, the interrupt pulse and the branch-taken flag are due one clock after the accepting edge. `in_ready` follows `res_ready` in the same cycle. The bench keeps a behavioural model that updates on each rising edge from the same inputs. All outputs are compared against it on every cycle, late in the clock period and after the inputs have settled, so the checks line up with the one-cycle delay without counting it ad hoc. The `res_ready` stalls exercise the hold rule.

// File: rtl/dsc_decide_pkg.sv
package dsc_decide_pkg;
  typedef enum logic [1:0] {
    POL_NEVER  = 2'b00,
    POL_IF_SET = 2'b01,
    POL_IF_CLR = 2'b10,
    POL_ALWAYS = 2'b11
  } pol_e;

  localparam int SEL_W       = 32;
  localparam int SEL_MASK_LO = 16;
  localparam int SEL_VAL_LO  = 0;
  localparam int DESC_BYTES  = 16;
  localparam int N_DECIDE    = 3;
  // decision slots; slot k owns policy bits [2k+1:2k]
  localparam int D_WAIT   = 0;
  localparam int D_BRANCH = 1;
  localparam int D_IRQ    = 2;
endpackage

// File: rtl/dsc_sel_match.sv
module dsc_sel_match #(
  parameter int SW = 4
) (
  input  logic [SW-1:0]                      stat,
  input  logic [dsc_decide_pkg::SEL_W-1:0]   sel,
  output logic                               hit
);
  import dsc_decide_pkg::*;
  logic [SW-1:0] mask, cmpv;
  assign mask = sel[SEL_MASK_LO +: SW];
  assign cmpv = sel[SEL_VAL_LO +: SW];
  assign hit  = ~|((stat ^ cmpv) & mask);
endmodule

// File: rtl/dsc_policy_gate.sv
module dsc_policy_gate (
  input  dsc_decide_pkg::pol_e pol,
  input  logic                 hit,
  output logic                 act
);
  import dsc_decide_pkg::*;
  always_comb begin
    unique case (pol)
      POL_NEVER:  act = 1'b0;
      POL_IF_SET: act = hit;
      POL_IF_CLR: act = ~hit;
      default:    act = 1'b1;
    endcase
  end
endmodule

// File: rtl/dsc_ptr_step.sv
module dsc_ptr_step #(
  parameter int AW   = 32,
  parameter int STEP = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] target,
  input  logic          take,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] INC = AW'(STEP);
  assign nxt = take ? target : cur + INC;
endmodule

// File: rtl/dsc_decide.sv
module dsc_decide #(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [2*dsc_decide_pkg::N_DECIDE-1:0] pol_bits,
  input  logic [SW-1:0]                      dev_stat,
  input  logic [dsc_decide_pkg::SEL_W-1:0]   irq_sel,
  input  logic [dsc_decide_pkg::SEL_W-1:0]   wait_sel,
  input  logic [dsc_decide_pkg::SEL_W-1:0]   br_sel,
  input  logic [AW-1:0]                      cmd_ptr,
  input  logic [AW-1:0]                      dep_addr,
  output logic                               res_valid,
  input  logic                               res_ready,
  output logic                               res_wait,
  output logic                               res_branch,
  output logic [AW-1:0]                      res_ptr,
  output logic                               irq_pulse,
  output logic                               bt_flag
);
  import dsc_decide_pkg::*;

  logic [SEL_W-1:0]    sel_arr [N_DECIDE];
  logic [N_DECIDE-1:0] hit, act;
  logic                stall, take, fire, accept;
  logic [AW-1:0]       step_ptr;

  assign sel_arr[D_WAIT]   = wait_sel;
  assign sel_arr[D_BRANCH] = br_sel;
  assign sel_arr[D_IRQ]    = irq_sel;

  for (genvar k = 0; k < N_DECIDE; k++) begin : g_dec
    dsc_sel_match #(.SW(SW)) u_match (
      .stat (dev_stat),
      .sel  (sel_arr[k]),
      .hit  (hit[k])
    );
    dsc_policy_gate u_gate (
      .pol (pol_e'(pol_bits[2*k +: 2])),
      .hit (hit[k]),
      .act (act[k])
    );
  end

  assign stall = act[D_WAIT];
  assign take  = act[D_BRANCH] & ~stall;
  assign fire  = act[D_IRQ] & ~stall;

  dsc_ptr_step #(.AW(AW), .STEP(DESC_BYTES)) u_step (
    .cur    (cmd_ptr),
    .target (dep_addr),
    .take   (take),
    .nxt    (step_ptr)
  );

  assign in_ready = ~res_valid | res_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_wait   <= 1'b0;
      res_branch <= 1'b0;
      res_ptr    <= '0;
      irq_pulse  <= 1'b0;
      bt_flag    <= 1'b0;
    end else begin
      irq_pulse <= accept & fire;
      if (accept) begin
        res_valid  <= 1'b1;
        res_wait   <= stall;
        res_branch <= take;
        res_ptr    <= stall ? cmd_ptr : step_ptr;
        if (!stall) bt_flag <= take;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsc_decide_chk.sv
module dsc_decide_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [AW-1:0] cmd_ptr,
  input logic          res_valid,
  input logic          res_ready,
  input logic          res_wait,
  input logic          res_branch,
  input logic [AW-1:0] res_ptr,
  input logic          irq_pulse,
  input logic          bt_flag
);
  localparam logic [AW-1:0] INC = AW'(dsc_decide_pkg::DESC_BYTES);

  assert_irq_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (res_valid && $past(in_valid && in_ready)));

  assert_stall_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !res_wait);

  assert_stall_no_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_wait) |-> !res_branch);

  assert_bt_only_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(bt_flag));

  assert_step_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready) && res_valid && !res_wait && !res_branch)
      |-> (res_ptr == $past(cmd_ptr) + INC && !bt_flag));

  assert_hold_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_ptr)
      && $stable(res_branch) && $stable(res_wait)));
endmodule

bind dsc_decide dsc_decide_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cmd_ptr(cmd_ptr), .res_valid(res_valid), .res_ready(res_ready),
  .res_wait(res_wait), .res_branch(res_branch), .res_ptr(res_ptr),
  .irq_pulse(irq_pulse), .bt_flag(bt_flag)
);

// File: tb/sim_dsc_decide.sv
`timescale 1ns/1ps
module sim_dsc_decide;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, res_ready = 1;
  logic [5:0] pol_bits = 0;
  logic [3:0] dev_stat = 0;
  logic [31:0] irq_sel = 0, wait_sel = 0, br_sel = 0;
  logic [AW-1:0] cmd_ptr = 0, dep_addr = 0;
  logic res_valid, res_wait, res_branch, irq_pulse, bt_flag;
  logic [AW-1:0] res_ptr;

  always #4 clk = ~clk;

  dsc_decide #(.AW(AW), .SW(4)) u0 (.*);

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R8";
  bit bp_on = 0;

  // reference model state
  bit m_valid, m_wait, m_br, m_irq, m_bt;
  logic [AW-1:0] m_ptr;

  function automatic bit cond_of(input logic [3:0] st, input logic [31:0] sel);
    bit c = 1;
    for (int i = 0; i < 4; i++)
      if (sel[16+i] && (st[i] != sel[i])) c = 0;
    return c;
  endfunction

  function automatic bit pol_act(input logic [1:0] p, input bit c);
    case (p)
      2'd0: return 0;
      2'd1: return c;
      2'd2: return !c;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    bit acc, w, b, q;
    if (!rst_n) begin
      m_valid = 0; m_wait = 0; m_br = 0; m_irq = 0; m_bt = 0; m_ptr = 0;
    end else begin
      acc = in_valid && (!m_valid || res_ready);
      m_irq = 0;
      if (acc) begin
        w = pol_act(pol_bits[1:0], cond_of(dev_stat, wait_sel));
        b = pol_act(pol_bits[3:2], cond_of(dev_stat, br_sel));
        q = pol_act(pol_bits[5:4], cond_of(dev_stat, irq_sel));
        m_valid = 1;
        m_wait = w;
        m_br = b && !w;
        m_irq = q && !w;
        if (w) m_ptr = cmd_ptr;
        else begin
          m_ptr = b ? dep_addr : cmd_ptr + 16;
          m_bt = b;
        end
      end else if (res_ready) m_valid = 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) %s actual=%0h expected=%0h", req, phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #6;
    if (rst_n) begin
      chk("R7", "in_ready", in_ready, !m_valid || res_ready);
      chk("R7", "res_valid", res_valid, m_valid);
      chk("R2", "irq_pulse", irq_pulse, m_irq);
      chk("R4", "bt_flag", bt_flag, m_bt);
      if (m_valid) begin
        chk("R3", "res_wait", res_wait, m_wait);
        chk("R4", "res_branch", res_branch, m_br);
        chk("R5", "res_ptr", res_ptr, m_ptr);
      end
    end
  end

  always @(negedge clk) if (bp_on) res_ready <= $urandom_range(0, 2) != 0; else res_ready <= 1;

  task automatic send(input logic [5:0] p, input logic [3:0] st, input logic [31:0] is,
                      input logic [31:0] ws, input logic [31:0] bs,
                      input logic [AW-1:0] cp, input logic [AW-1:0] da);
    bit r;
    @(negedge clk);
    in_valid = 1; pol_bits = p; dev_stat = st; irq_sel = is; wait_sel = ws; br_sel = bs;
    cmd_ptr = cp; dep_addr = da;
    forever begin
      #1 r = in_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R8", "res_valid", res_valid, 0);
    chk("R8", "irq_pulse", irq_pulse, 0);
    chk("R8", "bt_flag", bt_flag, 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    // R9: each field alone selects its own decision
    phase = "R9";
    send(6'b11_00_00, 4'h0, 0, 0, 0, 32'h100, 32'h800);   // irq only
    send(6'b00_11_00, 4'h0, 0, 0, 0, 32'h110, 32'h800);   // branch only
    send(6'b00_00_11, 4'h0, 0, 0, 0, 32'h120, 32'h800);   // wait only
    idle(2);
    // R1: masked compare, zero mask, partial mask
    phase = "R1";
    send(6'b01_01_00, 4'h5, 32'h0000_000A, 0, 32'h0000_000A, 32'h200, 32'h900);
    send(6'b01_01_00, 4'hB, 32'h000A_000A, 0, 32'h000A_000A, 32'h210, 32'h900);
    send(6'b01_01_00, 4'hE, 32'h000A_000A, 0, 32'h000A_000A, 32'h220, 32'h900);
    send(6'b10_10_00, 4'hE, 32'h000A_000A, 0, 32'h000A_000A, 32'h230, 32'h900);
    idle(2);
    // R6: own select per decision, one snapshot
    phase = "R6";
    send(6'b01_01_01, 4'h3, 32'h000F_0003, 32'h000F_0000, 32'h000F_000C, 32'h300, 32'hA00);
    send(6'b01_10_00, 4'h3, 32'h000F_000C, 0, 32'h000F_0003, 32'h310, 32'hA00);
    idle(2);
    // R3: stall suppresses irq/branch and keeps BT
    phase = "R3";
    send(6'b11_11_00, 4'h0, 0, 0, 0, 32'h400, 32'hB00);
    send(6'b11_11_11, 4'h0, 0, 0, 0, 32'h410, 32'hB00);
    send(6'b11_11_10, 4'h1, 0, 32'h0001_0001, 0, 32'h420, 32'hB00);
    idle(2);
    // R4 / R5
    phase = "R4";
    send(6'b00_11_00, 4'h0, 0, 0, 0, 32'h500, 32'hC40);
    phase = "R5";
    send(6'b00_00_00, 4'h0, 0, 0, 0, 32'hFFFF_FFF0, 32'hC40);
    idle(2);
    // R7: back-pressure with mixed traffic
    phase = "R7";
    bp_on = 1;
    for (int i = 0; i < 300; i++) begin
      send(6'($urandom), 4'($urandom), {12'h0, 4'($urandom), 12'h0, 4'($urandom)},
           {12'h0, 4'($urandom), 12'h0, 4'($urandom)}, {12'h0, 4'($urandom), 12'h0, 4'($urandom)},
           {$urandom} & 32'hFFFF_FFF0, {$urandom} & 32'hFFFF_FFF0);
      if (i % 7 == 0) idle(3);
    end
    idle(8);
    bp_on = 0;
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule